// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing half of a FIFO-based serial port. A host reaches it through a small single-cycle register bus: a write enable, a read enable, a byte offset, write data and registered read data. It holds the configuration registers: character mode, bit-rate divisor, control, FIFO control and port. It keeps the five status flags for transmit and receive, and it drives the transmit and receive interrupt lines.

The block does not do the serial bit timing and does not store received bytes. Toward the transmit shifter it gives a one-cycle strobe that carries the byte just written. Toward the receive FIFO it gives a pop strobe and a flush strobe. From the FIFO it takes the occupancy, the head byte, a pulse for each byte pushed, an idle-timeout pulse and a break-detect pulse. From these it decides when the receive-full flag and the receive interrupt rise and fall. A flag is acknowledged by writing zero to its status bit. Reading the status register while the transmitter is enabled arms both transmit flags again.

Top module: `sercore_regfront`

## Requirements
- R1: A synchronous active-high reset sets the register values as follows. Transmit-end and transmit-empty are 1. Break, receive-full and data-ready are 0. Bit-rate is 0xFF and control is 0x20. Mode, port, FIFO control and read data are 0. Both interrupt lines are low.
- R2: Register offsets are 0x00 mode, 0x04 bit-rate, 0x08 control, 0x0C transmit data, 0x10 status, 0x14 receive data, 0x18 FIFO control, 0x1C data count, 0x20 port and 0x24 line status. Read data shows the addressed value one clock after read enable and holds it between reads.
- R3: Writes keep only the bits in a per-register mask: 0x7B for mode, 0xFA for control and 0xF3 for port. Bit-rate keeps 8 bits and FIFO control keeps all 16.
- R4: The status read value carries transmit-end in bit 6, transmit-empty in bit 5, break in bit 4, receive-full in bit 1 and data-ready in bit 0. All other bits read 0. Writing 0 to one of these bits clears that flag. Writing 1 leaves it unchanged.
- R5: A status read while control bit 5 (transmit enable) is 1 returns the flags as they were. It then sets transmit-empty and transmit-end. A status read with control bit 5 at 0 changes no flag.
- R6: A write to transmit data clears transmit-empty. On the next clock it gives a one-cycle tx_stb with tx_byte equal to the written low byte.
- R7: A control write with bit 5 at 0 sets transmit-end. A control write with bit 6 at 0 drops the receive interrupt. The transmit interrupt line equals control bit 7.
- R8: FIFO control bits 7:6 select the receive trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. A push that brings occupancy (rx_count + 1) to the trigger level or above sets receive-full. If control bit 6 is 1, that push also raises the receive interrupt.
- R9: A receive-data read with rx_count above 0 returns rx_data and pulses rx_pop on the next clock. If rx_count − 1 is below the trigger level, it clears receive-full. With rx_count at 0 the read returns 0 and gives no pop.
- R10: An idle-timeout pulse sets receive-full and data-ready. If control bit 6 is 1, it also raises the receive interrupt. A break-detect pulse sets the break flag.
- R11: A status write that puts 0 in bit 1 or in bit 0 drops the receive interrupt.
- R12: A FIFO-control write with bit 1 set gives a one-cycle rx_flush on the next clock.
- R13: The data-count register reads rx_count. Line status, transmit data and every unmapped offset read 0. A write to an unmapped offset changes no register, flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rx_count | input | CNT_W (5) | Receive FIFO occupancy |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_push | input | 1 | Pulse: a byte entered the receive FIFO |
| rx_timeout | input | 1 | Pulse: receive line idle timeout |
| brk_in | input | 1 | Pulse: break condition detected |
| rx_pop | output | 1 | Pulse: remove head byte from receive FIFO |
| rx_flush | output | 1 | Pulse: empty the receive FIFO |
| tx_stb | output | 1 | Pulse: byte for the transmit shifter |
| tx_byte | output | 8 | Byte carried by tx_stb |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |

## Verification
The assertions assume that the host never asserts write enable and read enable in the same cycle, so each cycle carries at most one bus operation. They also assume that rx_count reflects the occupancy before any push in that cycle. The checks on the receive interrupt only apply in cycles without a push or timeout pulse, because such a pulse legitimately raises the line again. The stimulus issues bus operations one at a time with a clock between them. It pulses the FIFO-side inputs only when the bus is idle, and it drives rx_count as a steady level that is set before each push or read.

// File: rtl/sercore_pkg.sv
package sercore_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int TRIG_W = 5;

  typedef logic [ADDR_W-1:0] ofs_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam ofs_t OFS_MODE  = 6'h00;
  localparam ofs_t OFS_RATE  = 6'h04;
  localparam ofs_t OFS_CTRL  = 6'h08;
  localparam ofs_t OFS_TXD   = 6'h0C;
  localparam ofs_t OFS_STAT  = 6'h10;
  localparam ofs_t OFS_RXD   = 6'h14;
  localparam ofs_t OFS_FCTL  = 6'h18;
  localparam ofs_t OFS_COUNT = 6'h1C;
  localparam ofs_t OFS_PORT  = 6'h20;
  localparam ofs_t OFS_LINE  = 6'h24;

  // status bit positions (decoded by software)
  localparam int ST_TEND = 6;
  localparam int ST_TDRE = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;

  // control bit positions
  localparam int CT_TXIE = 7;
  localparam int CT_RXIE = 6;
  localparam int CT_TXEN = 5;

  // FIFO control fields
  localparam int FC_FLUSH = 1;
  localparam int FC_TRG_LO = 6;

  localparam byte_t MASK_MODE = 8'h7B;
  localparam byte_t MASK_CTRL = 8'hFA;
  localparam byte_t MASK_PORT = 8'hF3;

  localparam byte_t RST_RATE = 8'hFF;
  localparam byte_t RST_CTRL = 8'h20;

  function automatic logic [TRIG_W-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = TRIG_W'(1);
      2'd1:    trig_level = TRIG_W'(4);
      2'd2:    trig_level = TRIG_W'(8);
      default: trig_level = TRIG_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/sercore_cfg.sv
module sercore_cfg
  import sercore_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ofs_t              addr,
  input  logic [DATA_W-1:0] wdata,
  output byte_t             mode_q,
  output byte_t             rate_q,
  output byte_t             ctrl_q,
  output logic [DATA_W-1:0] fctl_q,
  output byte_t             port_q,
  output logic [TRIG_W-1:0] trig,
  output logic              tx_irq,
  output logic              rx_flush
);
  logic wr_mode, wr_rate, wr_ctrl, wr_fctl, wr_port;

  always_comb begin
    wr_mode = wr_en && (addr == OFS_MODE);
    wr_rate = wr_en && (addr == OFS_RATE);
    wr_ctrl = wr_en && (addr == OFS_CTRL);
    wr_fctl = wr_en && (addr == OFS_FCTL);
    wr_port = wr_en && (addr == OFS_PORT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      rate_q   <= RST_RATE;
      ctrl_q   <= RST_CTRL;
      fctl_q   <= '0;
      port_q   <= '0;
      rx_flush <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata[BYTE_W-1:0] & MASK_MODE;
      if (wr_rate) rate_q <= wdata[BYTE_W-1:0];
      if (wr_ctrl) ctrl_q <= wdata[BYTE_W-1:0] & MASK_CTRL;
      if (wr_fctl) fctl_q <= wdata;
      if (wr_port) port_q <= wdata[BYTE_W-1:0] & MASK_PORT;
      rx_flush <= wr_fctl && wdata[FC_FLUSH];
    end
  end

  assign trig   = trig_level(fctl_q[FC_TRG_LO+1:FC_TRG_LO]);
  assign tx_irq = ctrl_q[CT_TXIE];

  assert_txirq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (tx_irq == $past(wdata[CT_TXIE])));

  assert_flush_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_fctl && wdata[FC_FLUSH]) |=> rx_flush);

  assert_flush_single_R12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == OFS_FCTL) |=> !rx_flush);
endmodule

// File: rtl/sercore_flags.sv
module sercore_flags
  import sercore_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  ofs_t              addr,
  input  byte_t             wbyte,
  input  logic              txen,
  input  logic              rxie,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              rx_timeout,
  input  logic              brk_in,
  output byte_t             status,
  output logic              rx_irq,
  output logic              tx_stb,
  output byte_t             tx_byte,
  output logic              rx_pop
);
  localparam int CMP_W = (CNT_W > TRIG_W ? CNT_W : TRIG_W) + 1;

  logic f_tend, f_tdre, f_brk, f_rdf, f_dr;
  logic n_tend, n_tdre, n_brk, n_rdf, n_dr, n_irq;
  logic wr_ctrl, wr_txd, wr_stat, rd_stat, rd_rxd;
  logic [CMP_W-1:0] cnt_up, cnt_dn, trig_x;
  logic has_data;

  always_comb begin
    wr_ctrl  = wr_en && (addr == OFS_CTRL);
    wr_txd   = wr_en && (addr == OFS_TXD);
    wr_stat  = wr_en && (addr == OFS_STAT);
    rd_stat  = rd_en && (addr == OFS_STAT);
    rd_rxd   = rd_en && (addr == OFS_RXD);
    has_data = (rx_count != '0);
    cnt_up   = CMP_W'(rx_count) + CMP_W'(1);
    cnt_dn   = CMP_W'(rx_count) - CMP_W'(1);
    trig_x   = CMP_W'(trig);
  end

  // next-state: bus-side clears first, then event-side sets win
  always_comb begin
    n_tend = f_tend;
    n_tdre = f_tdre;
    n_brk  = f_brk;
    n_rdf  = f_rdf;
    n_dr   = f_dr;
    n_irq  = rx_irq;
    if (wr_ctrl) begin
      if (!wbyte[CT_TXEN]) n_tend = 1'b1;
      if (!wbyte[CT_RXIE]) n_irq  = 1'b0;
    end
    if (wr_txd) n_tdre = 1'b0;
    if (wr_stat) begin
      if (!wbyte[ST_TEND]) n_tend = 1'b0;
      if (!wbyte[ST_TDRE]) n_tdre = 1'b0;
      if (!wbyte[ST_BRK])  n_brk  = 1'b0;
      if (!wbyte[ST_RDF])  n_rdf  = 1'b0;
      if (!wbyte[ST_DR])   n_dr   = 1'b0;
      if (!wbyte[ST_RDF] || !wbyte[ST_DR]) n_irq = 1'b0;
    end
    if (rd_stat && txen) begin
      n_tend = 1'b1;
      n_tdre = 1'b1;
    end
    if (rd_rxd && has_data && (cnt_dn < trig_x)) n_rdf = 1'b0;
    if (rx_push && (cnt_up >= trig_x)) begin
      n_rdf = 1'b1;
      if (rxie) n_irq = 1'b1;
    end
    if (rx_timeout) begin
      n_rdf = 1'b1;
      n_dr  = 1'b1;
      if (rxie) n_irq = 1'b1;
    end
    if (brk_in) n_brk = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_tend  <= 1'b1;
      f_tdre  <= 1'b1;
      f_brk   <= 1'b0;
      f_rdf   <= 1'b0;
      f_dr    <= 1'b0;
      rx_irq  <= 1'b0;
      tx_stb  <= 1'b0;
      tx_byte <= '0;
      rx_pop  <= 1'b0;
    end else begin
      f_tend <= n_tend;
      f_tdre <= n_tdre;
      f_brk  <= n_brk;
      f_rdf  <= n_rdf;
      f_dr   <= n_dr;
      rx_irq <= n_irq;
      tx_stb <= wr_txd;
      if (wr_txd) tx_byte <= wbyte;
      rx_pop <= rd_rxd && has_data;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TEND] = f_tend;
    status[ST_TDRE] = f_tdre;
    status[ST_BRK]  = f_brk;
    status[ST_RDF]  = f_rdf;
    status[ST_DR]   = f_dr;
  end

  assert_txd_clears_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_TXD && !rd_en) |=> !status[ST_TDRE]);

  assert_txd_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_TXD) |=> (tx_stb && tx_byte == $past(wbyte)));

  assert_status_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_STAT && txen) |=> (status[ST_TEND] && status[ST_TDRE]));

  assert_ctrl_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CTRL && !wbyte[CT_RXIE] && !rx_push && !rx_timeout)
      |=> !rx_irq);

  assert_stat_drops_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STAT && !(wbyte[ST_RDF] && wbyte[ST_DR])
      && !rx_push && !rx_timeout) |=> !rx_irq);

  assert_pop_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_RXD && rx_count == '0) |=> !rx_pop);

  assert_timeout_sets_R10: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |=> (status[ST_RDF] && status[ST_DR]));
endmodule

// File: rtl/sercore_rdmux.sv
module sercore_rdmux
  import sercore_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  ofs_t              addr,
  input  byte_t             mode_q,
  input  byte_t             rate_q,
  input  byte_t             ctrl_q,
  input  byte_t             status,
  input  logic [DATA_W-1:0] fctl_q,
  input  byte_t             port_q,
  input  logic [CNT_W-1:0]  rx_count,
  input  byte_t             rx_data,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (addr)
      OFS_MODE:  sel = DATA_W'(mode_q);
      OFS_RATE:  sel = DATA_W'(rate_q);
      OFS_CTRL:  sel = DATA_W'(ctrl_q);
      OFS_STAT:  sel = DATA_W'(status);
      OFS_RXD:   sel = (rx_count != '0) ? DATA_W'(rx_data) : '0;
      OFS_FCTL:  sel = fctl_q;
      OFS_COUNT: sel = DATA_W'(rx_count);
      OFS_PORT:  sel = DATA_W'(port_q);
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  assert_line_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_LINE) |=> (rdata == '0));

  assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_count_read_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_COUNT) |=> (rdata == DATA_W'($past(rx_count))));
endmodule

// File: rtl/sercore_regfront.sv
module sercore_regfront
  import sercore_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_push,
  input  logic              rx_timeout,
  input  logic              brk_in,
  output logic              rx_pop,
  output logic              rx_flush,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_irq,
  output logic              rx_irq
);
  byte_t             mode_q, rate_q, ctrl_q, port_q, status;
  logic [DATA_W-1:0] fctl_q;
  logic [TRIG_W-1:0] trig;

  sercore_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .mode_q   (mode_q),
    .rate_q   (rate_q),
    .ctrl_q   (ctrl_q),
    .fctl_q   (fctl_q),
    .port_q   (port_q),
    .trig     (trig),
    .tx_irq   (tx_irq),
    .rx_flush (rx_flush)
  );

  sercore_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wbyte      (wdata[BYTE_W-1:0]),
    .txen       (ctrl_q[CT_TXEN]),
    .rxie       (ctrl_q[CT_RXIE]),
    .trig       (trig),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .rx_timeout (rx_timeout),
    .brk_in     (brk_in),
    .status     (status),
    .rx_irq     (rx_irq),
    .tx_stb     (tx_stb),
    .tx_byte    (tx_byte),
    .rx_pop     (rx_pop)
  );

  sercore_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .mode_q   (mode_q),
    .rate_q   (rate_q),
    .ctrl_q   (ctrl_q),
    .status   (status),
    .fctl_q   (fctl_q),
    .port_q   (port_q),
    .rx_count (rx_count),
    .rx_data  (rx_data),
    .rdata    (rdata)
  );
endmodule

// File: tb/sim_sercore_regfront.sv
`timescale 1ns/1ps
module sim_sercore_regfront;
  localparam int CLK_NS = 20;
  localparam int CW = 5;
  localparam int NV = 31;

  // row: [39:38] op (1 write, 2 read+compare), [37:32] offset, [31:16] data, [15:0] expected
  localparam logic [39:0] VEC [NV] = '{
    {2'd2, 6'h10, 16'h0000, 16'h0060},
    {2'd2, 6'h08, 16'h0000, 16'h0020},
    {2'd2, 6'h04, 16'h0000, 16'h00FF},
    {2'd2, 6'h00, 16'h0000, 16'h0000},
    {2'd2, 6'h20, 16'h0000, 16'h0000},
    {2'd2, 6'h18, 16'h0000, 16'h0000},
    {2'd1, 6'h00, 16'hFFFF, 16'h0000},
    {2'd2, 6'h00, 16'h0000, 16'h007B},
    {2'd1, 6'h08, 16'h00FF, 16'h0000},
    {2'd2, 6'h08, 16'h0000, 16'h00FA},
    {2'd1, 6'h20, 16'hFFFF, 16'h0000},
    {2'd2, 6'h20, 16'h0000, 16'h00F3},
    {2'd1, 6'h04, 16'h1234, 16'h0000},
    {2'd2, 6'h04, 16'h0000, 16'h0034},
    {2'd1, 6'h18, 16'hABCD, 16'h0000},
    {2'd2, 6'h18, 16'h0000, 16'hABCD},
    {2'd2, 6'h24, 16'h0000, 16'h0000},
    {2'd2, 6'h28, 16'h0000, 16'h0000},
    {2'd2, 6'h0C, 16'h0000, 16'h0000},
    {2'd1, 6'h2C, 16'hFFFF, 16'h0000},
    {2'd2, 6'h00, 16'h0000, 16'h007B},
    {2'd1, 6'h08, 16'h0000, 16'h0000},
    {2'd2, 6'h08, 16'h0000, 16'h0000},
    {2'd1, 6'h0C, 16'h0055, 16'h0000},
    {2'd2, 6'h10, 16'h0000, 16'h0040},
    {2'd2, 6'h10, 16'h0000, 16'h0040},
    {2'd1, 6'h10, 16'h0000, 16'h0000},
    {2'd2, 6'h10, 16'h0000, 16'h0000},
    {2'd1, 6'h08, 16'h0020, 16'h0000},
    {2'd2, 6'h10, 16'h0000, 16'h0000},
    {2'd2, 6'h10, 16'h0000, 16'h0060}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [CW-1:0] rx_count = '0;
  logic [7:0] rx_data = '0;
  logic rx_push = 1'b0, rx_timeout = 1'b0, brk_in = 1'b0;
  logic rx_pop, rx_flush, tx_stb, tx_irq, rx_irq;
  logic [7:0] tx_byte;

  int n_chk = 0, n_bad = 0;
  logic [15:0] v;

  always #(CLK_NS/2) clk = ~clk;

  sercore_regfront u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_count(rx_count), .rx_data(rx_data),
    .rx_push(rx_push), .rx_timeout(rx_timeout), .brk_in(brk_in),
    .rx_pop(rx_pop), .rx_flush(rx_flush), .tx_stb(tx_stb), .tx_byte(tx_byte),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic push(input logic [CW-1:0] c);
    @(negedge clk); rx_count = c; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pulse_timeout();
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_in = 1'b1;
    @(negedge clk); brk_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 tx_irq", {15'd0, tx_irq}, 16'h0);
    chk("R1 rx_irq", {15'd0, rx_irq}, 16'h0);
    chk("R1 tx_stb", {15'd0, tx_stb}, 16'h0);

    // R1 R2 R3 R4 R5 R13 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39:38] == 2'd1) bus_wr(VEC[i][37:32], VEC[i][31:16]);
      else begin
        bus_rd(VEC[i][37:32], v);
        chk($sformatf("R2 table row %0d (R1 R3 R4 R5 R13)", i), v, VEC[i][15:0]);
      end
    end

    // R6 transmit strobe
    bus_wr(6'h0C, 16'h77A5);
    chk("R6 tx_stb", {15'd0, tx_stb}, 16'h1);
    chk("R6 tx_byte", {8'd0, tx_byte}, 16'h00A5);
    @(negedge clk);
    chk("R6 tx_stb single", {15'd0, tx_stb}, 16'h0);
    bus_rd(6'h10, v);
    chk("R6 empty cleared", v & 16'h0020, 16'h0);

    // R7 control side effects
    bus_wr(6'h08, 16'h0080);
    chk("R7 tx_irq high", {15'd0, tx_irq}, 16'h1);
    bus_wr(6'h10, 16'h0000);
    bus_rd(6'h10, v);
    chk("R4 all cleared", v, 16'h0000);
    bus_wr(6'h08, 16'h0080);
    bus_rd(6'h10, v);
    chk("R7 tend set by ctrl", v, 16'h0040);

    // R8 trigger 4 with rx interrupt enabled
    bus_wr(6'h18, 16'h0040);
    bus_wr(6'h08, 16'h0040);
    chk("R7 tx_irq low", {15'd0, tx_irq}, 16'h0);
    push(5'd2);
    chk("R8 below trig irq", {15'd0, rx_irq}, 16'h0);
    bus_rd(6'h10, v);
    chk("R8 below trig rdf", v & 16'h0002, 16'h0);
    push(5'd3);
    chk("R8 at trig irq", {15'd0, rx_irq}, 16'h1);
    bus_rd(6'h10, v);
    chk("R8 at trig rdf", v & 16'h0002, 16'h0002);

    // R11 status write drops irq
    bus_wr(6'h10, 16'h00FD);
    chk("R11 irq dropped", {15'd0, rx_irq}, 16'h0);
    bus_rd(6'h10, v);
    chk("R11 rdf cleared", v & 16'h0002, 16'h0);

    // R10 timeout and break
    pulse_timeout();
    chk("R10 timeout irq", {15'd0, rx_irq}, 16'h1);
    bus_rd(6'h10, v);
    chk("R10 rdf and dr", v & 16'h0003, 16'h0003);
    pulse_brk();
    bus_rd(6'h10, v);
    chk("R10 break flag", v & 16'h0010, 16'h0010);

    // R7 control write with bit 6 clear
    bus_wr(6'h08, 16'h0000);
    chk("R7 rx_irq dropped", {15'd0, rx_irq}, 16'h0);

    // R9 receive data reads (trigger 4)
    rx_data = 8'h3C;
    rx_count = 5'd5;
    bus_rd(6'h14, v);
    chk("R9 data", v, 16'h003C);
    chk("R9 pop", {15'd0, rx_pop}, 16'h1);
    @(negedge clk);
    chk("R9 pop single", {15'd0, rx_pop}, 16'h0);
    bus_rd(6'h10, v);
    chk("R9 rdf kept", v & 16'h0002, 16'h0002);
    rx_count = 5'd4;
    bus_rd(6'h14, v);
    chk("R9 pop again", {15'd0, rx_pop}, 16'h1);
    bus_rd(6'h10, v);
    chk("R9 rdf cleared", v & 16'h0002, 16'h0);
    rx_count = 5'd0;
    bus_rd(6'h14, v);
    chk("R9 empty data", v, 16'h0);
    chk("R9 empty no pop", {15'd0, rx_pop}, 16'h0);

    // R8 trigger 8 and 14
    bus_wr(6'h18, 16'h0080);
    push(5'd6);
    bus_rd(6'h10, v);
    chk("R8 trig8 below", v & 16'h0002, 16'h0);
    push(5'd7);
    bus_rd(6'h10, v);
    chk("R8 trig8 at", v & 16'h0002, 16'h0002);
    bus_wr(6'h10, 16'h00FD);
    bus_wr(6'h18, 16'h00C0);
    push(5'd12);
    bus_rd(6'h10, v);
    chk("R8 trig14 below", v & 16'h0002, 16'h0);
    push(5'd13);
    bus_rd(6'h10, v);
    chk("R8 trig14 at", v & 16'h0002, 16'h0002);
    bus_wr(6'h10, 16'h00FD);

    // R12 flush strobe, trigger back to 1
    bus_wr(6'h18, 16'h0002);
    chk("R12 flush", {15'd0, rx_flush}, 16'h1);
    @(negedge clk);
    chk("R12 flush single", {15'd0, rx_flush}, 16'h0);
    push(5'd0);
    bus_rd(6'h10, v);
    chk("R8 trig1 first byte", v & 16'h0002, 16'h0002);

    // R13 data count
    rx_count = 5'd9;
    bus_rd(6'h1C, v);
    chk("R13 count 9", v, 16'h0009);
    rx_count = 5'd16;
    bus_rd(6'h1C, v);
    chk("R13 count 16", v, 16'h0010);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", rdata, 16'h0);
    bus_rd(6'h08, v);
    chk("R1 ctrl after reset", v, 16'h0020);
    bus_rd(6'h18, v);
    chk("R1 fifo ctrl after reset", v, 16'h0000);
    bus_rd(6'h10, v);
    chk("R1 status after reset", v, 16'h0060);

    finish_run();
  end
endmodule